// File: doc/BRIEF.md
# Stochastic Bitstream Encoder

This block turns a 16-bit unsigned probability into a serial stochastic stream, one bit per enabled clock. A 16-bit maximal-length shift register supplies a fresh pseudo-random word on every enabled cycle. A magnitude comparator emits a 1 whenever that word lies below the probability input. Over a long run, the share of ones in the stream therefore approaches the probability divided by 65,536.

Each instance takes its own seed, which is loaded while reset is asserted. This lets many encoders run side by side without sharing a random source, so their streams stay uncorrelated. A length counter marks the end of every group of `STREAM_LEN` bits with a one-cycle pulse, so a downstream counter or accumulator knows when a stream window is complete.

Top module: `prob_stream_enc`

## Requirements
- R1: While `rst_ni` is low, `bit_o` and `eos_o` are 0, the random register holds `seed_i`, and the length count is zero.
- R2: On each enabled cycle the register shifts left by one. Bit 0 takes the XOR of bits 15, 13 and 12 and bit 10 of the old value, which is the polynomial x^16+x^14+x^13+x^11+1.
- R3: If `seed_i` is 0 at reset, the register is loaded with 16'hACE1 instead, and it never holds all zeros.
- R4: On an enabled cycle, `bit_o` is registered as 1 exactly when the current register value is strictly below `prob_i`. A probability of 0 gives only zeros.
- R5: While `en_i` is low, the register, `bit_o` and the length count hold their values, and `eos_o` is 0.
- R6: `eos_o` is high for exactly one cycle, in the same cycle as the `STREAM_LEN`-th enabled bit of each group. The count then wraps to zero.
- R7: The register sequence has a period of 65,535 enabled cycles. Over one full period, the number of ones on `bit_o` equals `prob_i` - 1 for any nonzero constant `prob_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; loads the seed |
| en_i | input | 1 | Advance enable |
| seed_i | input | 16 | Per-instance seed, sampled during reset |
| prob_i | input | 16 | Unsigned probability value |
| bit_o | output | 1 | Stochastic stream bit |
| eos_o | output | 1 | One-cycle end-of-stream pulse |

## Verification
The last bit of a length window and the end-of-stream pulse come out in the same cycle. A bit produced on the edge where the count wraps must therefore carry both a correct comparison and the pulse. The bench provokes this by toggling `en_i` at random, so that some window boundaries land just before or just after an idle cycle. A behavioural model predicts the bit, the pulse and the count independently, and these are compared with the outputs on every clock. A full-period run at a fixed probability then checks the exact ones count, which confirms both the sequence length and the strict less-than comparison.

// File: rtl/sc_enc_pkg.sv
package sc_enc_pkg;
  localparam int unsigned LFSR_W       = 16;
  localparam logic [LFSR_W-1:0] TAP_MASK      = 16'hB400; // bits 15,13,12,10
  localparam logic [LFSR_W-1:0] SEED_FALLBACK = 16'hACE1;
  typedef logic [LFSR_W-1:0] lfsr_t;
endpackage

// File: rtl/sc_enc_lfsr.sv
module sc_enc_lfsr
  import sc_enc_pkg::*;
#(
  parameter int unsigned W        = LFSR_W,
  parameter logic [W-1:0] TAPS     = TAP_MASK,
  parameter logic [W-1:0] FALLBACK = SEED_FALLBACK
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] seed_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] seed_safe;
  logic [W-1:0] tap_bits;
  logic         fb;

  assign seed_safe = (seed_i == '0) ? FALLBACK : seed_i;

  for (genvar i = 0; i < W; i++) begin : g_tap
    assign tap_bits[i] = TAPS[i] & state_q[i];
  end
  assign fb = ^tap_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   state_q <= seed_safe;
    else if (en_i) state_q <= {state_q[W-2:0], fb};
  end

  assign state_o = state_q;

  assert_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(state_q));
  assert_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> state_q[W-1:1] == $past(state_q[W-2:0]));
endmodule

// File: rtl/sc_enc_cmp.sv
module sc_enc_cmp #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] rnd_i,
  input  logic [W-1:0] prob_i,
  output logic         bit_o
);
  logic bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bit_q <= 1'b0;
    else if (en_i) bit_q <= (rnd_i < prob_i);
  end

  assign bit_o = bit_q;

  assert_zero_prob_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && prob_i == '0) |=> !bit_q);
  assert_bit_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(bit_q));
endmodule

// File: rtl/sc_enc_len_cnt.sv
module sc_enc_len_cnt #(
  parameter int unsigned LEN   = 256,
  localparam int unsigned CNT_W = (LEN > 2) ? $clog2(LEN) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic eos_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;
  logic             eos_q;

  // power-of-two lengths wrap naturally; others need an explicit clear
  if ((LEN & (LEN - 1)) == 0) begin : g_pow2
    assign at_last = &cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   cnt_q <= '0;
      else if (en_i) cnt_q <= cnt_q + 1'b1;
    end
  end else begin : g_any
    assign at_last = (cnt_q == LAST);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   cnt_q <= '0;
      else if (en_i) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eos_q <= 1'b0;
    else         eos_q <= en_i & at_last;
  end

  assign eos_o = eos_q;

  assert_cnt_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_eos_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_q |=> !eos_q);
  assert_eos_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_q |-> cnt_q == '0);
  assert_cnt_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(cnt_q) && !eos_q));
endmodule

// File: rtl/prob_stream_enc.sv
module prob_stream_enc
  import sc_enc_pkg::*;
#(
  parameter int unsigned STREAM_LEN = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic [LFSR_W-1:0] prob_i,
  output logic              bit_o,
  output logic              eos_o
);
  lfsr_t rnd;

  sc_enc_lfsr #(
    .W       (LFSR_W),
    .TAPS    (TAP_MASK),
    .FALLBACK(SEED_FALLBACK)
  ) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .seed_i (seed_i),
    .state_o(rnd)
  );

  sc_enc_cmp #(.W(LFSR_W)) u_cmp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .rnd_i (rnd),
    .prob_i(prob_i),
    .bit_o (bit_o)
  );

  sc_enc_len_cnt #(.LEN(STREAM_LEN)) u_len (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .eos_o (eos_o)
  );

  assert_eos_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_o |-> $past(en_i));
endmodule

// File: tb/prob_stream_enc_bench.sv
module prob_stream_enc_bench;
  localparam int L = 256;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [15:0] seed_i = 16'h1234;
  logic [15:0] prob_i = 16'h0;
  logic        bit_o, eos_o;

  always #5 clk_i = ~clk_i;

  prob_stream_enc #(.STREAM_LEN(L)) u_prob_stream_enc (
    .clk_i, .rst_ni, .en_i, .seed_i, .prob_i, .bit_o, .eos_o
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model
  int unsigned m_state;
  bit          m_bit, m_eos;
  int          m_cnt;
  string       tag;

  function automatic int unsigned next_state(int unsigned s);
    int unsigned fb;
    fb = ((s >> 15) ^ (s >> 13) ^ (s >> 12) ^ (s >> 10)) & 1;
    return ((s << 1) | fb) & 32'hFFFF;
  endfunction

  task automatic chk(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d exp %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [15:0] s);
    @(negedge clk_i);
    rst_ni = 1'b0; en_i = 1'b0; seed_i = s;
    @(negedge clk_i);
    tag = "R1";
    chk("bit_o in reset", bit_o, 0);
    chk("eos_o in reset", eos_o, 0);
    m_state = (s == 16'h0) ? 32'hACE1 : s;
    m_bit = 0; m_eos = 0; m_cnt = 0;
    rst_ni = 1'b1;
  endtask

  // inputs already applied after a negedge; advance one clock and compare
  task automatic step(input bit en, input logic [15:0] p);
    en_i = en; prob_i = p;
    @(posedge clk_i);
    if (en) begin
      m_bit = (m_state < p);
      m_state = next_state(m_state);
      m_cnt++;
      if (m_cnt == L) begin m_eos = 1; m_cnt = 0; end
      else m_eos = 0;
    end else m_eos = 0;
    @(negedge clk_i);
    chk("bit_o", bit_o, m_bit);
    chk("eos_o", eos_o, m_eos);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int ones;
    int eos_seen;

    // R1/R2/R4: seeded start, random probabilities, always enabled
    do_reset(16'h1234);
    tag = "R2";
    for (int i = 0; i < 600; i++) step(1'b1, 16'($urandom));

    // R4: zero probability yields only zeros
    tag = "R4";
    for (int i = 0; i < 300; i++) begin
      step(1'b1, 16'h0);
      chk("bit_o zero prob", bit_o, 0);
    end
    // R4: full probability yields one except at state FFFF
    for (int i = 0; i < 100; i++) step(1'b1, 16'hFFFF);

    // R5/R6: random enable gaps across window boundaries
    tag = "R6";
    eos_seen = 0;
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) != 0, 16'($urandom));
      if (eos_o) eos_seen++;
    end
    chk("eos pulses seen nonzero", (eos_seen > 0), 1);

    // R5: long idle with changing prob, output and state must hold
    tag = "R5";
    for (int i = 0; i < 50; i++) step(1'b0, 16'($urandom));
    for (int i = 0; i < 50; i++) step(1'b1, 16'($urandom));

    // R3: zero seed substitutes fallback
    do_reset(16'h0);
    tag = "R3";
    for (int i = 0; i < 400; i++) step(1'b1, 16'($urandom));

    // R1: a different seed, fresh window count
    do_reset(16'hBEEF);
    tag = "R1";
    eos_seen = 0;
    for (int i = 0; i < L; i++) begin
      step(1'b1, 16'($urandom));
      if (eos_o) eos_seen++;
    end
    tag = "R6";
    chk("eos on L-th bit after reset", eos_o, 1);
    chk("eos count one window", eos_seen, 1);

    // R7: full period ones count
    do_reset(16'h0001);
    tag = "R7";
    ones = 0;
    for (int i = 0; i < 65535; i++) begin
      step(1'b1, 16'h8000);
      if (bit_o) ones++;
    end
    chk("ones over full period", ones, 32767);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule